// File: doc/BRIEF.md
# Oscillator Health Flag and Output Control Register

This block keeps the status and control bits of a serial real-time clock that do not belong to the time counters: a sticky flag reporting that the 32.768 kHz oscillator has failed, a stop bit that halts the oscillator, and an output-level bit that drives an open-drain output pin. It takes register writes from the bus interface and returns, for each register address, only the bit it owns (bit 7). The neighbouring counter logic supplies the other bits, and the two are OR-merged on read.

A tick watchdog runs on the system clock and counts the cycles between oscillator ticks. If no tick arrives within `TIMEOUT_CYC` cycles, or if the stop bit is 1, a stop event occurs and the fail flag is set. A qualification state machine has three states. `OSC_HALTED` is the state after reset and after every stop event. The first tick with no stop event pending moves it to `OSC_SETTLING` (transition *restart*). In `OSC_SETTLING` it counts ticks; after `RUN_TICKS` further ticks it moves to `OSC_TRUSTED` (transition *qualify*). From any state a stop event returns it to `OSC_HALTED` (transition *stop*). Software can clear the fail flag only while the machine is in `OSC_TRUSTED`. With the default `RUN_TICKS`, this is four seconds of uninterrupted oscillation.

Top module: `oscfail_ctrl`

## Requirements
- R1: After reset the fail flag is 1, the output-level bit is 1 (the pin is released, `pin_pull_low` = 0), and the stop bit is 0 (`osc_enable` = 1).
- R2: A write to address 7 loads data bit 7 into the output-level bit. From the next cycle on, `pin_pull_low` is 1 when the bit is 0 and 0 when it is 1.
- R3: A write to address 0 loads data bit 7 into the stop bit. From the next cycle on, `osc_enable` is the inverse of the stop bit.
- R4: While the stop bit is 1, the fail flag is 1 from the second cycle after the write onward.
- R5: When no tick has been seen for `TIMEOUT_CYC` system cycles, the fail flag becomes 1. Gaps shorter than that leave it unchanged.
- R6: A write of 0 to bit 7 of address 1 (the clear) has no effect on the fail flag unless `RUN_TICKS` ticks have followed the restart tick since the last stop event.
- R7: Once qualified, a clear write makes the fail flag read 0 from the next cycle on.
- R8: A write of 1 to bit 7 of address 1 never changes the fail flag.
- R9: `rd_data` drives only bit 7: the stop bit at address 0, the fail flag at address 1, and the output-level bit at address 7. All other bits are 0, including control bit 5, which always reads 0. Every other address reads 0x00.
- R10: A stop event during settling restarts qualification. A full `RUN_TICKS` run after a fresh restart tick is needed again before a clear is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| osc_tick | input | 1 | One-cycle pulse per 32.768 kHz oscillator period, already synchronised |
| wr_en | input | 1 | Register write strobe from the bus interface |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Bit-7 contribution for `rd_addr`, other bits 0 |
| osc_enable | output | 1 | Run enable to the oscillator, inverse of the stop bit |
| pin_pull_low | output | 1 | Open-drain pull-down enable for the output pin |

## Verification
The hardest situation to reach is a stop event in the middle of settling, followed by a clear. The clear must then be refused because qualification restarted, even though more than `RUN_TICKS` ticks have arrived since reset in total. The bench builds the block with a short timeout and a short run count. It drives ticks from a gated generator and switches the generator off for longer than the timeout partway through a run. After that it counts ticks again and tries the clear both before and after a fresh full run.

// File: rtl/oscflag_pkg.sv
package oscflag_pkg;

    typedef enum logic [1:0] {
        OSC_HALTED   = 2'd0,
        OSC_SETTLING = 2'd1,
        OSC_TRUSTED  = 2'd2
    } osc_state_e;

    localparam logic [2:0] ADDR_SECS = 3'd0;
    localparam logic [2:0] ADDR_MINS = 3'd1;
    localparam logic [2:0] ADDR_CTRL = 3'd7;
    localparam int         OWN_BIT   = 7;

endpackage

// File: rtl/osc_tick_watchdog.sv
module osc_tick_watchdog #(
    parameter int TIMEOUT_CYC = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic timeout
);
    localparam int GW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [GW-1:0] GAP_MAX = GW'(TIMEOUT_CYC);

    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gap_q <= '0;
        else if (tick)
            gap_q <= '0;
        else if (gap_q != GAP_MAX)
            gap_q <= gap_q + 1'b1;
    end

    assign timeout = (gap_q == GAP_MAX);

    // a tick always clears the gap, so no timeout directly after it
    assert_tick_clears_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !timeout);

endmodule

// File: rtl/osc_run_qualifier.sv
module osc_run_qualifier
    import oscflag_pkg::*;
#(
    parameter int RUN_TICKS = 131072
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       stop_evt,
    output osc_state_e state,
    output logic       trusted
);
    localparam int CW = $clog2(RUN_TICKS + 1);
    localparam logic [CW-1:0] LAST_TICK = CW'(RUN_TICKS - 1);

    osc_state_e state_q, state_d;
    logic [CW-1:0] run_q, run_d;

    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        if (stop_evt) begin
            state_d = OSC_HALTED;           // stop
            run_d   = '0;
        end else begin
            unique case (state_q)
                OSC_HALTED: if (tick) begin
                    state_d = OSC_SETTLING;  // restart
                    run_d   = '0;
                end
                OSC_SETTLING: if (tick) begin
                    if (run_q == LAST_TICK)
                        state_d = OSC_TRUSTED; // qualify
                    else
                        run_d = run_q + 1'b1;
                end
                OSC_TRUSTED: ;
                default: state_d = OSC_HALTED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OSC_HALTED;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    always_comb begin
        state   = state_q;
        trusted = (state_q == OSC_TRUSTED);
    end

    // trusted is reached only through settling
    assert_trust_via_settle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OSC_TRUSTED && $past(state_q) != OSC_TRUSTED) |-> ($past(state_q) == OSC_SETTLING));

    // a stop event always lands in halted
    assert_stop_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (state_q == OSC_HALTED));

endmodule

// File: rtl/oscfail_ctrl.sv
module oscfail_ctrl
    import oscflag_pkg::*;
#(
    parameter int TIMEOUT_CYC = 8192,
    parameter int RUN_TICKS   = 131072,
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              osc_enable,
    output logic              pin_pull_low
);
    logic stop_q, level_q, fail_q;
    logic timeout, stop_evt, trusted;
    logic wr_secs, wr_ctrl, wr_clear;
    osc_state_e qual_state;
    logic unused_state_bits;
    logic unused_wr_bits;

    assign unused_wr_bits    = ^wr_data[OWN_BIT-1:0];
    assign unused_state_bits = ^qual_state;

    osc_tick_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (osc_tick),
        .timeout (timeout)
    );

    assign stop_evt = stop_q | timeout;

    osc_run_qualifier #(.RUN_TICKS(RUN_TICKS)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (osc_tick),
        .stop_evt (stop_evt),
        .state    (qual_state),
        .trusted  (trusted)
    );

    always_comb begin
        wr_secs  = wr_en && (wr_addr == ADDR_W'(ADDR_SECS));
        wr_ctrl  = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
        wr_clear = wr_en && (wr_addr == ADDR_W'(ADDR_MINS)) && !wr_data[OWN_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_q  <= 1'b0;
            level_q <= 1'b1;
            fail_q  <= 1'b1;
        end else begin
            if (wr_secs) stop_q  <= wr_data[OWN_BIT];
            if (wr_ctrl) level_q <= wr_data[OWN_BIT];
            if (stop_evt)
                fail_q <= 1'b1;
            else if (wr_clear && trusted)
                fail_q <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADDR_SECS))      rd_data[OWN_BIT] = stop_q;
        else if (rd_addr == ADDR_W'(ADDR_MINS)) rd_data[OWN_BIT] = fail_q;
        else if (rd_addr == ADDR_W'(ADDR_CTRL)) rd_data[OWN_BIT] = level_q;
        osc_enable   = !stop_q;
        pin_pull_low = !level_q;
    end

    assert_pin_tracks_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(ADDR_CTRL)) |=> (pin_pull_low == !$past(wr_data[OWN_BIT])));

    assert_stop_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_q |=> fail_q);

    assert_timeout_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> fail_q);

    assert_clear_needs_trust_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fail_q) |-> $past(trusted));

    assert_clear_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clear && trusted && !stop_evt) |=> !fail_q);

endmodule

// File: tb/oscfail_ctrl_test.sv
module oscfail_ctrl_test;
    localparam int TO  = 20;
    localparam int RUN = 8;

    logic clk = 0, rst_n = 0, osc_tick = 0, wr_en = 0;
    logic [2:0] wr_addr = 0, rd_addr = 0;
    logic [7:0] wr_data = 0, rd_data;
    logic osc_enable, pin_pull_low;
    logic tick_on = 0;
    int total = 0, bad = 0;

    always #4 clk = ~clk;

    oscfail_ctrl #(.TIMEOUT_CYC(TO), .RUN_TICKS(RUN)) uut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .osc_enable(osc_enable), .pin_pull_low(pin_pull_low)
    );

    // tick every 10 system cycles while enabled
    initial forever begin
        repeat (9) @(negedge clk);
        osc_tick = tick_on;
        @(negedge clk);
        osc_tick = 0;
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a; #1 d = rd_data;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(3'd1, v); check("R1 flag", v, 8'h80);
        rd(3'd0, v); check("R1 stop", v, 8'h00);
        rd(3'd7, v); check("R1 level", v, 8'h80);
        check("R1 pin", {7'b0, pin_pull_low}, 8'h00);
        check("R1 osc_en", {7'b0, osc_enable}, 8'h01);
        rd(3'd3, v); check("R9 other addr", v, 8'h00);
    endtask

    task automatic t_early_clear;
        logic [7:0] v;
        tick_on = 1;
        repeat (30) @(negedge clk);
        wr(3'd1, 8'h00);
        rd(3'd1, v); check("R6 early clear ignored", v, 8'h80);
    endtask

    task automatic t_qual_clear;
        logic [7:0] v;
        repeat (100) @(negedge clk);
        wr(3'd1, 8'h7F);
        rd(3'd1, v); check("R7 clear accepted", v, 8'h00);
        wr(3'd1, 8'h80);
        rd(3'd1, v); check("R8 write one no effect", v, 8'h00);
    endtask

    task automatic t_out_pin;
        logic [7:0] v;
        wr(3'd7, 8'h00);
        check("R2 pin low", {7'b0, pin_pull_low}, 8'h01);
        rd(3'd7, v); check("R9 level 0", v, 8'h00);
        wr(3'd7, 8'hFF);
        check("R2 pin released", {7'b0, pin_pull_low}, 8'h00);
        rd(3'd7, v); check("R9 ctrl bit5 zero", v, 8'h80);
        rd(3'd1, v); check("R2 flag untouched", v, 8'h00);
    endtask

    task automatic t_stop_bit;
        logic [7:0] v;
        wr(3'd0, 8'h80);
        check("R3 osc disabled", {7'b0, osc_enable}, 8'h00);
        rd(3'd0, v); check("R9 stop readback", v, 8'h80);
        @(negedge clk);
        rd(3'd1, v); check("R4 flag set", v, 8'h80);
        repeat (40) @(negedge clk);
        wr(3'd1, 8'h00);
        rd(3'd1, v); check("R4 flag held while stopped", v, 8'h80);
        wr(3'd0, 8'h00);
        check("R3 osc enabled", {7'b0, osc_enable}, 8'h01);
        repeat (40) @(negedge clk);
        wr(3'd1, 8'h00);
        rd(3'd1, v); check("R6 clear ignored after stop", v, 8'h80);
        repeat (80) @(negedge clk);
        wr(3'd1, 8'h00);
        rd(3'd1, v); check("R7 clear after requal", v, 8'h00);
    endtask

    task automatic t_timeout;
        logic [7:0] v;
        tick_on = 0;
        repeat (5) @(negedge clk);
        rd(3'd1, v); check("R5 short gap no flag", v, 8'h00);
        repeat (30) @(negedge clk);
        rd(3'd1, v); check("R5 timeout flag", v, 8'h80);
    endtask

    task automatic t_restart;
        logic [7:0] v;
        tick_on = 1;
        repeat (50) @(negedge clk);
        tick_on = 0;
        repeat (30) @(negedge clk);
        tick_on = 1;
        repeat (50) @(negedge clk);
        wr(3'd1, 8'h00);
        rd(3'd1, v); check("R10 count restarted", v, 8'h80);
        repeat (60) @(negedge clk);
        wr(3'd1, 8'h00);
        rd(3'd1, v); check("R10 clear after full run", v, 8'h00);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1;
                @(negedge clk);
                t_reset();
                t_early_clear();
                t_qual_clear();
                t_out_pin();
                t_stop_bit();
                t_timeout();
                t_restart();
            end
            begin
                repeat (20000) @(negedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule